// File: doc/BRIEF.md
# Block Address to Cylinder/Head/Sector Translator

This block turns a linear block address and a transfer length into the five
bytes that a classic disk task file expects: the sector-count byte, the starting
sector number, the two cylinder bytes and the drive/head select byte. Each of two
drives keeps its own geometry, meaning a head count and a sectors-per-track
count. Software writes these through a small configuration port. Both default to
a shape with 16 heads and 17 sectors per track, so neither divisor is ever zero.

A one-cycle `start` strobe samples the drive number, the address and the count.
A bad count is rejected at once. A good request runs two back-to-back restoring
divisions, one quotient bit per clock. The first divides the address by the
track size (heads times sectors per track). The second divides the remainder by
sectors per track. The packed bytes then load into output registers together
with a one-cycle `done` pulse and an error code. The outputs hold until the next
accepted request completes. A start strobe during a conversion has no effect.

Top module: `lba_chs_xlate`

## Requirements
- R1: After reset, `done`, `busy`, `err` and all field outputs are 0, and both drives hold the default geometry of 16 heads and 17 sectors per track.
- R2: For an accepted request, the cylinder is the low 16 bits of `lba / (heads*spt)`. Bits 7:0 appear on `cyl_lo` and bits 15:8 appear on `cyl_hi`.
- R3: The head is `(lba mod (heads*spt)) / spt`. `sec_num` is `(lba mod spt) + 1`, so sectors are numbered from 1.
- R4: `drv_head` is `8'hA0 | (drive << 4) | (head & 4'hF)`. `head_hi` is 1 exactly when the head exceeds 7.
- R5: `sec_cnt` equals the low byte of `count` for counts 1 to 255. A count of 256 is encoded as 8'h00.
- R6: A count of 0 finishes with `err` = 2'd1. A count above 256 finishes with `err` = 2'd2. In both cases every field output keeps its prior value. An accepted request finishes with `err` = 2'd0.
- R7: `done` is high for exactly one cycle. For a rejected request, it is high in the cycle right after the accepting edge. For an accepted request, it is high 2*LBA_W+2 cycles after that edge.
- R8: A `start` arriving while `busy` is high is ignored. The result and its timing are those of the request already running.
- R9: A geometry write updates only the selected drive, and it leaves a head or sector field unchanged when the written value is 0.
- R10: `busy` is high from the edge that accepts a valid request until the edge that raises `done`, and it is low while `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Geometry write strobe |
| cfg_drive | input | 1 | Drive whose geometry is written |
| cfg_heads | input | GW | Head count to store (0 keeps the old value) |
| cfg_spt | input | GW | Sectors per track to store (0 keeps the old value) |
| start | input | 1 | Request strobe |
| drive | input | 1 | Drive selected by the request |
| lba | input | LBA_W | Linear block address |
| count | input | CNT_W | Number of blocks |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | 0 ok, 1 zero count, 2 count too large |
| sec_cnt | output | 8 | Encoded sector count |
| sec_num | output | GW | Starting sector, numbered from 1 |
| cyl_lo | output | 8 | Cylinder bits 7:0 |
| cyl_hi | output | 8 | Cylinder bits 15:8 |
| drv_head | output | 8 | Drive/head select byte |
| head_hi | output | 1 | Head above 7 |

## Verification
Directed cases use the default geometry at address 0 and at the last block of a track and of a cylinder. These show whether the sector is numbered from 1 and whether the head and cylinder roll over at the right remainder boundary. Further directed cases pick a head above 7, which tells the 4-bit head field apart from the separate high-head flag. Count values 0, 1, 255, 256 and 257 separate the encode path from both reject paths, and the reject cases confirm that the fields are held. Random geometries in both drives, including one-head and one-sector shapes, and random wide addresses exercise quotient truncation and drive independence. A second strobe sent in mid-conversion, and zero-valued geometry writes, show that both are ignored.

// File: rtl/lba_chs_pkg.sv
package lba_chs_pkg;
  typedef enum logic [1:0] {
    XERR_NONE = 2'd0,
    XERR_ZERO = 2'd1,
    XERR_MANY = 2'd2
  } xerr_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CYL  = 2'd1,
    ST_HEAD = 2'd2
  } xlate_st_t;

  localparam int NUM_DRV   = 2;
  localparam int MAX_BLKS  = 256;
  localparam logic [7:0] DH_MARK = 8'hA0;
endpackage

// File: rtl/lba_geom_regs.sv
module lba_geom_regs
  import lba_chs_pkg::*;
#(
  parameter int GW        = 8,
  parameter int DEF_HEADS = 16,
  parameter int DEF_SPT   = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          wr_drv,
  input  logic [GW-1:0] wr_heads,
  input  logic [GW-1:0] wr_spt,
  input  logic          rd_drv,
  output logic [GW-1:0] rd_heads,
  output logic [GW-1:0] rd_spt
);
  logic [GW-1:0] heads_q [NUM_DRV];
  logic [GW-1:0] spt_q   [NUM_DRV];

  for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
    always_ff @(posedge clk) begin
      if (rst) begin
        heads_q[d] <= GW'(DEF_HEADS);
        spt_q[d]   <= GW'(DEF_SPT);
      end else if (we && (int'(wr_drv) == d)) begin
        if (wr_heads != '0) heads_q[d] <= wr_heads;
        if (wr_spt   != '0) spt_q[d]   <= wr_spt;
      end
    end

    // R9: a stored divisor factor never becomes zero
    a_r9_geom_nonzero: assert property (@(posedge clk) disable iff (rst)
      (heads_q[d] != '0) && (spt_q[d] != '0));
  end

  assign rd_heads = heads_q[rd_drv];
  assign rd_spt   = spt_q[rd_drv];
endmodule

// File: rtl/lba_seq_div.sv
module lba_seq_div #(
  parameter int N = 32,
  parameter int D = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [N-1:0] dividend,
  input  logic [D-1:0] divisor,
  output logic         busy,
  output logic         valid,
  output logic [N-1:0] quot,
  output logic [D-1:0] rem
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0] sh_q;
  logic [D-1:0] r_q;
  logic [D-1:0] dvs_q;
  logic [CW-1:0] cnt_q;
  logic [D:0]   trial;
  logic         fits;

  assign trial = {r_q, sh_q[N-1]};
  assign fits  = trial >= {1'b0, dvs_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      valid <= 1'b0;
      sh_q  <= '0;
      r_q   <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
    end else begin
      valid <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy  <= 1'b1;
          sh_q  <= dividend;
          dvs_q <= divisor;
          r_q   <= '0;
          cnt_q <= CW'(N-1);
        end
      end else begin
        sh_q <= {sh_q[N-2:0], fits};
        if (fits) r_q <= D'(trial - {1'b0, dvs_q});
        else      r_q <= trial[D-1:0];
        if (cnt_q == '0) begin
          busy  <= 1'b0;
          valid <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign quot = sh_q;
  assign rem  = r_q;

  // R2: the remainder always lies below the divisor when results are valid
  a_r2_rem_below_divisor: assert property (@(posedge clk) disable iff (rst)
    valid |-> (rem < dvs_q));
  // R9: a launched division never sees a zero divisor
  a_r9_divisor_nonzero: assert property (@(posedge clk) disable iff (rst)
    (go && !busy) |-> (divisor != '0));
endmodule

// File: rtl/lba_chs_xlate.sv
module lba_chs_xlate
  import lba_chs_pkg::*;
#(
  parameter int LBA_W     = 32,
  parameter int CNT_W     = 16,
  parameter int GW        = 8,
  parameter int DEF_HEADS = 16,
  parameter int DEF_SPT   = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_drive,
  input  logic [GW-1:0]    cfg_heads,
  input  logic [GW-1:0]    cfg_spt,
  input  logic             start,
  input  logic             drive,
  input  logic [LBA_W-1:0] lba,
  input  logic [CNT_W-1:0] count,
  output logic             busy,
  output logic             done,
  output logic [1:0]       err,
  output logic [7:0]       sec_cnt,
  output logic [GW-1:0]    sec_num,
  output logic [7:0]       cyl_lo,
  output logic [7:0]       cyl_hi,
  output logic [7:0]       drv_head,
  output logic             head_hi
);
  localparam int TRK_W = 2 * GW;
  localparam int CYL_W = 16;

  xlate_st_t     st_q;
  logic          drv_q;
  logic [7:0]    cnt_enc_q;
  logic [GW-1:0] spt_q;
  logic [CYL_W-1:0] cyl_q;

  logic [GW-1:0]    g_heads, g_spt;
  logic [TRK_W-1:0] trk_size;
  logic             bad_zero, bad_many, accept, div_go;
  logic [LBA_W-1:0] div_dvd;
  logic [TRK_W-1:0] div_dvs;
  logic             dv_busy, dv_valid;
  logic [LBA_W-1:0] dv_quot;
  logic [TRK_W-1:0] dv_rem;
  logic [GW-1:0]    head_w;

  lba_geom_regs #(.GW(GW), .DEF_HEADS(DEF_HEADS), .DEF_SPT(DEF_SPT)) u_geom (
    .clk(clk), .rst(rst), .we(cfg_we), .wr_drv(cfg_drive),
    .wr_heads(cfg_heads), .wr_spt(cfg_spt),
    .rd_drv(drive), .rd_heads(g_heads), .rd_spt(g_spt)
  );

  assign trk_size = TRK_W'(g_heads) * TRK_W'(g_spt);
  assign bad_zero = (count == '0);
  assign bad_many = (count > CNT_W'(MAX_BLKS));
  assign accept   = start && (st_q == ST_IDLE);
  assign div_go   = (accept && !bad_zero && !bad_many) ||
                    ((st_q == ST_CYL) && dv_valid);
  assign div_dvd  = (st_q == ST_CYL) ? LBA_W'(dv_rem) : lba;
  assign div_dvs  = (st_q == ST_CYL) ? TRK_W'(spt_q) : trk_size;
  assign head_w   = dv_quot[GW-1:0];

  lba_seq_div #(.N(LBA_W), .D(TRK_W)) u_div (
    .clk(clk), .rst(rst), .go(div_go), .dividend(div_dvd), .divisor(div_dvs),
    .busy(dv_busy), .valid(dv_valid), .quot(dv_quot), .rem(dv_rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      drv_q     <= 1'b0;
      cnt_enc_q <= '0;
      spt_q     <= '0;
      cyl_q     <= '0;
      done      <= 1'b0;
      err       <= XERR_NONE;
      sec_cnt   <= '0;
      sec_num   <= '0;
      cyl_lo    <= '0;
      cyl_hi    <= '0;
      drv_head  <= '0;
      head_hi   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            if (bad_zero) begin
              err  <= XERR_ZERO;
              done <= 1'b1;
            end else if (bad_many) begin
              err  <= XERR_MANY;
              done <= 1'b1;
            end else begin
              drv_q     <= drive;
              spt_q     <= g_spt;
              cnt_enc_q <= count[7:0];
              st_q      <= ST_CYL;
            end
          end
        end
        ST_CYL: begin
          if (dv_valid) begin
            cyl_q <= dv_quot[CYL_W-1:0];
            st_q  <= ST_HEAD;
          end
        end
        ST_HEAD: begin
          if (dv_valid) begin
            sec_cnt  <= cnt_enc_q;
            sec_num  <= dv_rem[GW-1:0] + 1'b1;
            cyl_lo   <= cyl_q[7:0];
            cyl_hi   <= cyl_q[15:8];
            drv_head <= DH_MARK | {3'b000, drv_q, head_w[3:0]};
            head_hi  <= (head_w > GW'(7));
            err      <= XERR_NONE;
            done     <= 1'b1;
            st_q     <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st_q != ST_IDLE);

  // R7: completion is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10: busy is released by the time done is visible
  a_r10_busy_low_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R6: a zero count finishes next cycle with the zero-count code
  a_r6_zero_reject: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (count == '0)) |=> (done && (err == XERR_ZERO)));
  // R6: rejected request never starts a conversion
  a_r6_reject_no_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (count > CNT_W'(MAX_BLKS))) |=> !busy);
  // R3: a successful result never reports sector 0
  a_r3_sector_from_one: assert property (@(posedge clk) disable iff (rst)
    (done && (err == XERR_NONE) && $past(busy)) |-> (sec_num != '0));
  // R8: fields hold during a conversion until the completing edge
  a_r8_fields_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(cyl_lo) && $stable(sec_num) && $stable(drv_head)));
  // R4: marker bits of the drive/head byte after any success
  a_r4_marker_bits: assert property (@(posedge clk) disable iff (rst)
    (done && $past(busy)) |-> (drv_head[7:5] == 3'b101));
endmodule

// File: tb/lba_chs_xlate_test.sv
module lba_chs_xlate_test;
  localparam int LBA_W = 32;
  localparam int CNT_W = 16;
  localparam int GW    = 8;
  localparam int LAT   = 2 * LBA_W + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0, cfg_drive = 1'b0;
  logic [GW-1:0] cfg_heads = '0, cfg_spt = '0;
  logic start = 1'b0, drive = 1'b0;
  logic [LBA_W-1:0] lba = '0;
  logic [CNT_W-1:0] count = '0;
  logic busy, done, head_hi;
  logic [1:0] err;
  logic [7:0] sec_cnt, cyl_lo, cyl_hi, drv_head;
  logic [GW-1:0] sec_num;

  always #2 clk = ~clk;

  lba_chs_xlate #(.LBA_W(LBA_W), .CNT_W(CNT_W), .GW(GW)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_drive(cfg_drive),
    .cfg_heads(cfg_heads), .cfg_spt(cfg_spt), .start(start), .drive(drive),
    .lba(lba), .count(count), .busy(busy), .done(done), .err(err),
    .sec_cnt(sec_cnt), .sec_num(sec_num), .cyl_lo(cyl_lo), .cyl_hi(cyl_hi),
    .drv_head(drv_head), .head_hi(head_hi)
  );

  int n_chk = 0, n_fail = 0;
  int gh [2];
  int gs [2];
  logic [7:0] e_cnt, e_sec, e_clo, e_chi, e_dh;
  logic e_hh;
  int lat;
  bit wd_hit = 0;

  task automatic chk(input string tag, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic model(input int drv, input logic [LBA_W-1:0] a, input int c);
    longint trk, q, r, hd;
    trk = longint'(gh[drv]) * gs[drv];
    q = longint'(a) / trk;
    r = longint'(a) % trk;
    hd = r / gs[drv];
    e_clo = q[7:0];
    e_chi = q[15:8];
    e_sec = 8'((r % gs[drv]) + 1);
    e_cnt = (c == 256) ? 8'h00 : 8'(c);
    e_dh  = 8'hA0 | 8'(drv << 4) | 8'(hd & 15);
    e_hh  = hd > 7;
  endtask

  task automatic geo(input int drv, input int h, input int s);
    @(negedge clk);
    cfg_we = 1; cfg_drive = drv[0]; cfg_heads = GW'(h); cfg_spt = GW'(s);
    @(negedge clk);
    cfg_we = 0;
    if (h != 0) gh[drv] = h;
    if (s != 0) gs[drv] = s;
  endtask

  // run one request; optional second strobe in mid-flight (R8)
  task automatic run(input int drv, input logic [LBA_W-1:0] a, input int c, input bit poke);
    @(negedge clk);
    start = 1; drive = drv[0]; lba = a; count = CNT_W'(c);
    @(posedge clk);
    @(negedge clk);
    start = 0;
    lat = 0;
    while (!done && lat < 400) begin
      if (poke && lat == 5) begin
        start = 1; drive = ~drive; lba = ~a; count = 16'd3;
      end else start = 0;
      @(posedge clk); @(negedge clk);
      lat++;
    end
    start = 0;
  endtask

  task automatic expect_ok(input string tag);
    chk({tag, " R7 latency"}, lat, LAT);
    chk({tag, " R6 err"}, err, 0);
    chk({tag, " R2 cyl_lo"}, cyl_lo, e_clo);
    chk({tag, " R2 cyl_hi"}, cyl_hi, e_chi);
    chk({tag, " R3 sec_num"}, sec_num, e_sec);
    chk({tag, " R5 sec_cnt"}, sec_cnt, e_cnt);
    chk({tag, " R4 drv_head"}, drv_head, e_dh);
    chk({tag, " R4 head_hi"}, head_hi, e_hh);
    @(negedge clk);
    chk({tag, " R7 done single"}, done, 0);
  endtask

  task automatic expect_rej(input string tag, input int code);
    chk({tag, " R7 reject latency"}, lat, 0);
    chk({tag, " R6 code"}, err, code);
    chk({tag, " R6 hold cyl_lo"}, cyl_lo, e_clo);
    chk({tag, " R6 hold sec_num"}, sec_num, e_sec);
    chk({tag, " R6 hold drv_head"}, drv_head, e_dh);
    chk({tag, " R6 hold sec_cnt"}, sec_cnt, e_cnt);
    chk({tag, " R10 no busy"}, busy, 0);
  endtask

  initial begin
    #(4 * 150000);
    wd_hit = 1;
  end

  initial begin : main
    void'($urandom(32'h5EED_0042));
    gh[0] = 16; gs[0] = 17; gh[1] = 16; gs[1] = 17;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 done", done, 0); chk("R1 busy", busy, 0); chk("R1 err", err, 0);
    chk("R1 sec_num", sec_num, 0); chk("R1 drv_head", drv_head, 0);
    chk("R1 cyl", {cyl_hi, cyl_lo}, 0); chk("R1 sec_cnt", sec_cnt, 0);

    // R1 default geometry, R3 numbering from 1
    model(0, 0, 1); run(0, 0, 1, 0); expect_ok("lba0");
    model(0, 16, 255); run(0, 16, 255, 0); expect_ok("track end");
    model(0, 17, 256); run(0, 17, 256, 0); expect_ok("next head R5");
    model(0, 271, 2); run(0, 271, 2, 0); expect_ok("cyl end");
    model(0, 272, 2); run(0, 272, 2, 0); expect_ok("next cyl");
    model(1, 17 * 9 + 4, 7); run(1, 17 * 9 + 4, 7, 0); expect_ok("R4 head9 drv1");

    // R10 busy during conversion
    @(negedge clk); start = 1; drive = 0; lba = 5; count = 1;
    @(posedge clk); @(negedge clk); start = 0;
    chk("R10 busy after accept", busy, 1);
    while (!done) begin @(posedge clk); @(negedge clk); end
    chk("R10 busy low at done", busy, 0);
    model(0, 5, 1);

    // R6 rejects hold fields
    run(0, 77, 0, 0); expect_rej("zero count", 1);
    run(1, 77, 257, 0); expect_rej("257 count", 2);
    run(1, 77, 16'hFFFF, 0); expect_rej("max count", 2);

    // R8 start during busy ignored
    model(0, 32'h0001_2345, 9); run(0, 32'h0001_2345, 9, 1); expect_ok("R8 poke");

    // R9 geometry per drive, zero write ignored
    geo(1, 3, 0); geo(1, 0, 5);
    model(1, 1000, 4); run(1, 1000, 4, 0); expect_ok("R9 drv1 3x5");
    model(0, 1000, 4); run(0, 1000, 4, 0); expect_ok("R9 drv0 untouched");
    geo(0, 1, 1);
    model(0, 32'hDEAD_BEEF, 1); run(0, 32'hDEAD_BEEF, 1, 0); expect_ok("one by one");

    // random mix
    for (int i = 0; i < 40; i++) begin
      int d, c;
      logic [LBA_W-1:0] a;
      if ((i % 4) == 0) geo($urandom % 2, $urandom % 256, $urandom % 256);
      d = $urandom % 2;
      a = $urandom;
      c = ((i % 7) == 0) ? 256 : 1 + ($urandom % 256);
      model(d, a, c); run(d, a, c, 0); expect_ok("random");
    end

    if (wd_hit) chk("watchdog", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge wd_hit) begin
    n_chk++; n_fail++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule